// File: doc/BRIEF.md
# Pipeline Instruction Control Decoder

This block sits in the decode stage of a five-stage integer pipeline. It takes one 32-bit base-integer instruction and turns it, with no clock and no state, into the control flags that the execute, memory and write-back stages use. It also produces the three register indices and a sign-extended immediate. The execute stage uses one shared adder for everything. Load and store address arithmetic, branch targets and jump targets all go through the main ALU in add mode. The first ALU operand can therefore be switched from the register to the current PC.

Decoding depends on the opcode first. For ALU instructions, funct3 is then used, and bit 30 picks between the alternative forms. The raw index fields are always put out, even when the format reuses those bits for something else. The later stages simply ignore the ones they do not need. funct3 is also passed straight through so the execute stage can evaluate the branch condition. The recognised classes are register ALU, immediate ALU, load, store, conditional branch, load-upper-immediate and jump-and-link. Every other opcode decodes as a no-op.

Top module: `rvdec_top`

## Requirements
- R1: Opcode 0100011 (store) gives rf_we=0, dm_we=1, dm_re=0, op2_imm=1, op1_pc=0, alu_op=0 (add) and wb_sel=0.
- R2: The store immediate is instr[31:25] joined to instr[11:7] and sign-extended from bit 11. An offset of 188 gives imm=0x000000BC.
- R3: Opcode 0010011 (immediate ALU) gives rf_we=1, op2_imm=1, wb_sel=0 (ALU result) and imm = instr[31:20] sign-extended. With funct3 000 it gives alu_op=0 (add) whatever bit 30 holds.
- R4: Opcode 0000011 (load) gives rf_we=1, dm_re=1, dm_we=0, op2_imm=1, alu_op=0, wb_sel=1 (memory data) and the I-form immediate.
- R5: Opcode 1100011 (branch) gives do_branch=1, op1_pc=1, op2_imm=1, alu_op=0, rf_we=0, dm_we=0 and do_jump=0.
- R6: Opcode 0110011 (register ALU) gives rf_we=1, op1_pc=0, op2_imm=0, wb_sel=0 and imm=0. funct3 000 selects add (0), or sub (1) when bit 30 is set. The other funct3 codes map as 001→2 (sll), 010→3 (slt), 011→4 (sltu), 100→5 (xor), 101→6 (srl) or 7 (sra when bit 30 is set), 110→8 (or) and 111→9 (and).
- R7: Shift-immediate instructions (opcode 0010011, funct3 001 or 101) select alu_op 2, 6 or 7 with the same bit-30 rule as R6. Their imm is still the full I-form value, so bit 30 appears as imm bit 10.
- R8: rs1_idx=instr[19:15], rs2_idx=instr[24:20], rd_idx=instr[11:7] and funct3=instr[14:12] are output for every instruction. For I-form instructions, rs2_idx therefore equals imm[4:0].
- R9: Branch immediates are {instr[31],instr[7],instr[30:25],instr[11:8],0} and jump immediates are {instr[31],instr[19:12],instr[20],instr[30:21],0}. Both are sign-extended, so imm[0] is always 0.
- R10: Opcode 0110111 (load upper) gives rf_we=1, op2_imm=1, alu_op=10 (pass operand 2), wb_sel=0 and imm={instr[31:12],12'b0}.
- R11: Opcode 1101111 (jump-and-link) gives rf_we=1, do_jump=1, do_branch=0, op1_pc=1, op2_imm=1, alu_op=0 and wb_sel=2 (PC+4).
- R12: Any other opcode gives rf_we=0, dm_we=0, dm_re=0, do_branch=0, do_jump=0, op1_pc=0, op2_imm=0, alu_op=0, wb_sel=0 and imm=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word in the decode stage |
| rs1_idx | output | 5 | Raw first source index field |
| rs2_idx | output | 5 | Raw second source index field |
| rd_idx | output | 5 | Raw destination index field |
| funct3 | output | 3 | Raw funct3 field, used for the branch condition |
| imm | output | XLEN | Sign-extended immediate for the decoded format |
| rf_we | output | 1 | Register file write enable at write-back |
| dm_we | output | 1 | Data memory write enable |
| dm_re | output | 1 | Data memory read enable |
| op1_pc | output | 1 | ALU operand 1 is the PC rather than rs1 data |
| op2_imm | output | 1 | ALU operand 2 is the immediate rather than rs2 data |
| alu_op | output | 4 | ALU operation code (encoding per R6, R10) |
| wb_sel | output | 2 | Write-back source: 0 ALU, 1 memory, 2 PC+4 |
| do_branch | output | 1 | Conditional branch resolved in execute |
| do_jump | output | 1 | Unconditional jump |

## Verification
The assertions assume only that instr holds a settled, fully known 32-bit value whenever it is checked. They make no assumption about which opcodes arrive, because the no-op rule covers every pattern that is not recognised. The stimulus changes instr just after a rising clock edge and compares at the falling edge, so the combinational outputs have always settled before they are read. Random words are drawn with the opcode forced into each recognised class about as often as a fully random opcode, which also exercises the unrecognised space.

// File: rtl/rvdec_pkg.sv
package rvdec_pkg;

    localparam logic [6:0] OPC_OP     = 7'b0110011;
    localparam logic [6:0] OPC_OP_IMM = 7'b0010011;
    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_LUI    = 7'b0110111;
    localparam logic [6:0] OPC_JAL    = 7'b1101111;

    typedef enum logic [3:0] {
        ALU_ADD   = 4'd0,
        ALU_SUB   = 4'd1,
        ALU_SLL   = 4'd2,
        ALU_SLT   = 4'd3,
        ALU_SLTU  = 4'd4,
        ALU_XOR   = 4'd5,
        ALU_SRL   = 4'd6,
        ALU_SRA   = 4'd7,
        ALU_OR    = 4'd8,
        ALU_AND   = 4'd9,
        ALU_PASSB = 4'd10
    } alu_op_e;

    typedef enum logic [1:0] {
        WB_ALU = 2'd0,
        WB_MEM = 2'd1,
        WB_PC4 = 2'd2
    } wb_sel_e;

    typedef enum logic [2:0] {
        FMT_NONE = 3'd0,
        FMT_I    = 3'd1,
        FMT_S    = 3'd2,
        FMT_B    = 3'd3,
        FMT_U    = 3'd4,
        FMT_J    = 3'd5
    } imm_fmt_e;

    typedef struct packed {
        logic     rf_we;
        logic     dm_we;
        logic     dm_re;
        logic     op1_pc;
        logic     op2_imm;
        alu_op_e  alu_op;
        wb_sel_e  wb_sel;
        logic     do_branch;
        logic     do_jump;
        imm_fmt_e fmt;
    } ctrl_t;

    // funct3 to ALU operation; alt is instruction bit 30, sub_ok marks register form
    function automatic alu_op_e funct_to_alu(input logic [2:0] f3, input logic alt,
                                             input logic sub_ok);
        alu_op_e op;
        case (f3)
            3'b000:  op = (alt && sub_ok) ? ALU_SUB : ALU_ADD;
            3'b001:  op = ALU_SLL;
            3'b010:  op = ALU_SLT;
            3'b011:  op = ALU_SLTU;
            3'b100:  op = ALU_XOR;
            3'b101:  op = alt ? ALU_SRA : ALU_SRL;
            3'b110:  op = ALU_OR;
            default: op = ALU_AND;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/rvdec_fields.sv
module rvdec_fields
    import rvdec_pkg::*;
#(
    parameter int unsigned IDX_W = 5
) (
    input  logic [31:0]      instr,
    output logic [6:0]       opcode,
    output logic [2:0]       funct3,
    output logic             alt_bit,
    output logic [IDX_W-1:0] rs1_idx,
    output logic [IDX_W-1:0] rs2_idx,
    output logic [IDX_W-1:0] rd_idx
);
    localparam int unsigned RD_LO  = 7;
    localparam int unsigned RS1_LO = 15;
    localparam int unsigned RS2_LO = 20;

    logic unused_hi;

    always_comb begin
        opcode  = instr[6:0];
        funct3  = instr[14:12];
        alt_bit = instr[30];
        rd_idx  = instr[RD_LO  +: IDX_W];
        rs1_idx = instr[RS1_LO +: IDX_W];
        rs2_idx = instr[RS2_LO +: IDX_W];
    end

    assign unused_hi = ^{instr[31], instr[29:25]};

endmodule

// File: rtl/rvdec_ctrl.sv
module rvdec_ctrl
    import rvdec_pkg::*;
(
    input  logic [6:0] opcode,
    input  logic [2:0] funct3,
    input  logic       alt_bit,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl           = '0;
        ctrl.alu_op    = ALU_ADD;
        ctrl.wb_sel    = WB_ALU;
        ctrl.fmt       = FMT_NONE;
        case (opcode)
            OPC_OP: begin
                ctrl.rf_we  = 1'b1;
                ctrl.alu_op = funct_to_alu(funct3, alt_bit, 1'b1);
            end
            OPC_OP_IMM: begin
                ctrl.rf_we   = 1'b1;
                ctrl.op2_imm = 1'b1;
                ctrl.alu_op  = funct_to_alu(funct3, alt_bit, 1'b0);
                ctrl.fmt     = FMT_I;
            end
            OPC_LOAD: begin
                ctrl.rf_we   = 1'b1;
                ctrl.dm_re   = 1'b1;
                ctrl.op2_imm = 1'b1;
                ctrl.wb_sel  = WB_MEM;
                ctrl.fmt     = FMT_I;
            end
            OPC_STORE: begin
                ctrl.dm_we   = 1'b1;
                ctrl.op2_imm = 1'b1;
                ctrl.fmt     = FMT_S;
            end
            OPC_BRANCH: begin
                ctrl.do_branch = 1'b1;
                ctrl.op1_pc    = 1'b1;
                ctrl.op2_imm   = 1'b1;
                ctrl.fmt       = FMT_B;
            end
            OPC_LUI: begin
                ctrl.rf_we   = 1'b1;
                ctrl.op2_imm = 1'b1;
                ctrl.alu_op  = ALU_PASSB;
                ctrl.fmt     = FMT_U;
            end
            OPC_JAL: begin
                ctrl.rf_we   = 1'b1;
                ctrl.do_jump = 1'b1;
                ctrl.op1_pc  = 1'b1;
                ctrl.op2_imm = 1'b1;
                ctrl.wb_sel  = WB_PC4;
                ctrl.fmt     = FMT_J;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rvdec_immgen.sv
module rvdec_immgen
    import rvdec_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [31:0]     instr,
    input  imm_fmt_e        fmt,
    output logic [XLEN-1:0] imm
);
    localparam int unsigned SHORT_W = 12;
    localparam int unsigned BR_W    = 13;
    localparam int unsigned JMP_W   = 21;
    localparam int unsigned UP_W    = 32;

    logic [SHORT_W-1:0] raw_i;
    logic [SHORT_W-1:0] raw_s;
    logic [BR_W-1:0]    raw_b;
    logic [JMP_W-1:0]   raw_j;
    logic [UP_W-1:0]    raw_u;
    logic               unused_lo;

    always_comb begin
        raw_i = instr[31:20];
        raw_s = {instr[31:25], instr[11:7]};
        raw_b = {instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};
        raw_j = {instr[31], instr[19:12], instr[20], instr[30:21], 1'b0};
        raw_u = {instr[31:12], 12'b0};
    end

    always_comb begin
        case (fmt)
            FMT_I:   imm = {{(XLEN-SHORT_W){raw_i[SHORT_W-1]}}, raw_i};
            FMT_S:   imm = {{(XLEN-SHORT_W){raw_s[SHORT_W-1]}}, raw_s};
            FMT_B:   imm = {{(XLEN-BR_W){raw_b[BR_W-1]}}, raw_b};
            FMT_J:   imm = {{(XLEN-JMP_W){raw_j[JMP_W-1]}}, raw_j};
            FMT_U:   imm = XLEN'($signed(raw_u));
            default: imm = '0;
        endcase
    end

    assign unused_lo = ^instr[6:0];

endmodule

// File: rtl/rvdec_top.sv
module rvdec_top
    import rvdec_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [31:0]     instr,
    output logic [4:0]      rs1_idx,
    output logic [4:0]      rs2_idx,
    output logic [4:0]      rd_idx,
    output logic [2:0]      funct3,
    output logic [XLEN-1:0] imm,
    output logic            rf_we,
    output logic            dm_we,
    output logic            dm_re,
    output logic            op1_pc,
    output logic            op2_imm,
    output logic [3:0]      alu_op,
    output logic [1:0]      wb_sel,
    output logic            do_branch,
    output logic            do_jump
);
    localparam int unsigned IDX_W = 5;

    logic [6:0] opcode;
    logic       alt_bit;
    ctrl_t      ctrl;

    rvdec_fields #(.IDX_W(IDX_W)) u_fields (
        .instr   (instr),
        .opcode  (opcode),
        .funct3  (funct3),
        .alt_bit (alt_bit),
        .rs1_idx (rs1_idx),
        .rs2_idx (rs2_idx),
        .rd_idx  (rd_idx)
    );

    rvdec_ctrl u_ctrl (
        .opcode  (opcode),
        .funct3  (funct3),
        .alt_bit (alt_bit),
        .ctrl    (ctrl)
    );

    rvdec_immgen #(.XLEN(XLEN)) u_imm (
        .instr (instr),
        .fmt   (ctrl.fmt),
        .imm   (imm)
    );

    always_comb begin
        rf_we     = ctrl.rf_we;
        dm_we     = ctrl.dm_we;
        dm_re     = ctrl.dm_re;
        op1_pc    = ctrl.op1_pc;
        op2_imm   = ctrl.op2_imm;
        alu_op    = ctrl.alu_op;
        wb_sel    = ctrl.wb_sel;
        do_branch = ctrl.do_branch;
        do_jump   = ctrl.do_jump;
    end

endmodule

// File: rtl/rvdec_chk.sv
module rvdec_chk
    import rvdec_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input logic [31:0]     instr,
    input logic [4:0]      rs2_idx,
    input logic [XLEN-1:0] imm,
    input logic            rf_we,
    input logic            dm_we,
    input logic            dm_re,
    input logic            op1_pc,
    input logic            op2_imm,
    input logic [3:0]      alu_op,
    input logic [1:0]      wb_sel,
    input logic            do_branch,
    input logic            do_jump
);
    logic [6:0] opc;
    logic       known;

    always_comb begin
        opc   = instr[6:0];
        known = (opc == OPC_OP) || (opc == OPC_OP_IMM) || (opc == OPC_LOAD) ||
                (opc == OPC_STORE) || (opc == OPC_BRANCH) || (opc == OPC_LUI) ||
                (opc == OPC_JAL);
    end

    always_comb begin
        if (opc == OPC_STORE) begin
            p_store_flags_r1: assert (!rf_we && dm_we && op2_imm && alu_op == 4'd0);
        end
        if (opc == OPC_LOAD) begin
            p_load_flags_r4: assert (rf_we && dm_re && !dm_we && wb_sel == 2'd1);
        end
        if (opc == OPC_BRANCH) begin
            p_branch_flags_r5: assert (do_branch && op1_pc && op2_imm && !rf_we);
        end
        if (opc == OPC_OP_IMM || opc == OPC_LOAD) begin
            p_rs2_alias_r8: assert (rs2_idx == imm[4:0]);
        end
        if (opc == OPC_BRANCH || opc == OPC_JAL) begin
            p_even_target_r9: assert (imm[0] == 1'b0);
        end
        if (opc == OPC_LUI) begin
            p_upper_imm_r10: assert (imm[11:0] == 12'd0 && rf_we);
        end
        if (opc == OPC_JAL) begin
            p_jal_link_r11: assert (do_jump && !do_branch && wb_sel == 2'd2);
        end
        if (!known) begin
            p_unknown_nop_r12: assert (!rf_we && !dm_we && !dm_re && !do_branch && !do_jump);
        end
        p_single_writer_r1: assert (!(rf_we && dm_we));
    end

endmodule

bind rvdec_top rvdec_chk #(.XLEN(XLEN)) u_chk (
    .instr     (instr),
    .rs2_idx   (rs2_idx),
    .imm       (imm),
    .rf_we     (rf_we),
    .dm_we     (dm_we),
    .dm_re     (dm_re),
    .op1_pc    (op1_pc),
    .op2_imm   (op2_imm),
    .alu_op    (alu_op),
    .wb_sel    (wb_sel),
    .do_branch (do_branch),
    .do_jump   (do_jump)
);

// File: tb/sim_rvdec_top.sv
module sim_rvdec_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 3000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = 32'd0;

    logic [4:0]  rs1_idx, rs2_idx, rd_idx;
    logic [2:0]  funct3;
    logic [31:0] imm;
    logic        rf_we, dm_we, dm_re, op1_pc, op2_imm, do_branch, do_jump;
    logic [3:0]  alu_op;
    logic [1:0]  wb_sel;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    rvdec_top u0 (
        .instr(instr), .rs1_idx(rs1_idx), .rs2_idx(rs2_idx), .rd_idx(rd_idx),
        .funct3(funct3), .imm(imm), .rf_we(rf_we), .dm_we(dm_we), .dm_re(dm_re),
        .op1_pc(op1_pc), .op2_imm(op2_imm), .alu_op(alu_op), .wb_sel(wb_sel),
        .do_branch(do_branch), .do_jump(do_jump)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input string what, input logic [31:0] got,
                         input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s instr=%h actual=%h expected=%h", tag, what, instr, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // ---------------- behavioural reference ----------------
    logic [31:0] e_imm;
    logic        e_rf, e_dw, e_dr, e_p1, e_p2, e_br, e_jp;
    int          e_alu, e_wb;
    string       e_tag, e_itag;

    task automatic ref_dec(input logic [31:0] i);
        int v;
        int base [8] = '{0, 2, 3, 4, 5, 6, 8, 9};
        e_rf = 0; e_dw = 0; e_dr = 0; e_p1 = 0; e_p2 = 0; e_br = 0; e_jp = 0;
        e_alu = 0; e_wb = 0; e_imm = 0; e_tag = "R12"; e_itag = "R12";
        case (i[6:0])
            7'h33: begin
                e_tag = "R6"; e_itag = "R6"; e_rf = 1;
                e_alu = base[i[14:12]];
                if (i[30] && i[14:12] == 3'd0) e_alu = 1;
                if (i[30] && i[14:12] == 3'd5) e_alu = 7;
            end
            7'h13: begin
                e_tag = (i[13:12] == 2'b01) ? "R7" : "R3"; e_itag = "R3";
                e_rf = 1; e_p2 = 1;
                e_alu = base[i[14:12]];
                if (i[30] && i[14:12] == 3'd5) e_alu = 7;
            end
            7'h03: begin
                e_tag = "R4"; e_itag = "R4"; e_rf = 1; e_dr = 1; e_p2 = 1; e_wb = 1;
            end
            7'h23: begin e_tag = "R1"; e_itag = "R2"; e_dw = 1; e_p2 = 1; end
            7'h63: begin e_tag = "R5"; e_itag = "R9"; e_br = 1; e_p1 = 1; e_p2 = 1; end
            7'h37: begin e_tag = "R10"; e_itag = "R10"; e_rf = 1; e_p2 = 1; e_alu = 10; end
            7'h6f: begin
                e_tag = "R11"; e_itag = "R9"; e_rf = 1; e_jp = 1; e_p1 = 1; e_p2 = 1; e_wb = 2;
            end
            default: ;
        endcase
        case (i[6:0])
            7'h13, 7'h03: begin
                v = int'(i[31:20]); if (i[31]) v -= 4096; e_imm = 32'(v);
            end
            7'h23: begin
                v = int'(i[31:25]) * 32 + int'(i[11:7]); if (i[31]) v -= 4096; e_imm = 32'(v);
            end
            7'h63: begin
                v = int'(i[11:8]) * 2 + int'(i[30:25]) * 32 + int'(i[7]) * 2048;
                if (i[31]) v -= 4096; e_imm = 32'(v);
            end
            7'h6f: begin
                v = int'(i[30:21]) * 2 + int'(i[20]) * 2048 + int'(i[19:12]) * 4096;
                if (i[31]) v -= (1 << 20); e_imm = 32'(v);
            end
            7'h37: e_imm = {i[31:12], 12'h000};
            default: ;
        endcase
    endtask

    // every falling edge: compare the whole output set against the model
    always @(negedge clk) begin
        if (!done) begin
            ref_dec(instr);
            check(e_tag, "rf_we", 32'(rf_we), 32'(e_rf));
            check(e_tag, "dm_we", 32'(dm_we), 32'(e_dw));
            check(e_tag, "dm_re", 32'(dm_re), 32'(e_dr));
            check(e_tag, "op1_pc", 32'(op1_pc), 32'(e_p1));
            check(e_tag, "op2_imm", 32'(op2_imm), 32'(e_p2));
            check(e_tag, "alu_op", 32'(alu_op), 32'(e_alu));
            check(e_tag, "wb_sel", 32'(wb_sel), 32'(e_wb));
            check(e_tag, "do_branch", 32'(do_branch), 32'(e_br));
            check(e_tag, "do_jump", 32'(do_jump), 32'(e_jp));
            check(e_itag, "imm", imm, e_imm);
            check("R8", "rs1_idx", 32'(rs1_idx), 32'(instr[19:15]));
            check("R8", "rs2_idx", 32'(rs2_idx), 32'(instr[24:20]));
            check("R8", "rd_idx", 32'(rd_idx), 32'(instr[11:7]));
            check("R8", "funct3", 32'(funct3), 32'(instr[14:12]));
        end
    end

    // ---------------- encoders ----------------
    function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2,
            input logic [4:0] rs1, input logic [2:0] f3, input logic [4:0] rd);
        return {f7, rs2, rs1, f3, rd, 7'h33};
    endfunction
    function automatic logic [31:0] enc_i(input logic [11:0] im, input logic [4:0] rs1,
            input logic [2:0] f3, input logic [4:0] rd, input logic [6:0] op);
        return {im, rs1, f3, rd, op};
    endfunction
    function automatic logic [31:0] enc_s(input logic [11:0] im, input logic [4:0] rs2,
            input logic [4:0] rs1);
        return {im[11:5], rs2, rs1, 3'b010, im[4:0], 7'h23};
    endfunction
    function automatic logic [31:0] enc_b(input logic [12:0] im, input logic [4:0] rs2,
            input logic [4:0] rs1, input logic [2:0] f3);
        return {im[12], im[10:5], rs2, rs1, f3, im[4:1], im[11], 7'h63};
    endfunction
    function automatic logic [31:0] enc_j(input logic [20:0] im, input logic [4:0] rd);
        return {im[20], im[10:1], im[11], im[19:12], rd, 7'h6f};
    endfunction

    task automatic apply(input logic [31:0] w);
        @(posedge clk);
        #1 instr = w;
        @(negedge clk);
        #1;
    endtask

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] lfsr;
        logic [6:0]  ops [7] = '{7'h33, 7'h13, 7'h03, 7'h23, 7'h63, 7'h37, 7'h6f};
        lfsr = 32'h1ACE_B00C;
        instr = 32'd0;
        repeat (2) @(negedge clk);
        #1;
        check("R12", "reset rf_we", 32'(rf_we), 32'd0);
        check("R12", "reset dm_we", 32'(dm_we), 32'd0);
        @(posedge clk);
        rst = 1'b0;

        apply(enc_s(12'd188, 5'd10, 5'd0));            // store a0 to 188(x0)
        check("R2", "store imm 188", imm, 32'h0000_00BC);
        check("R1", "store dm_we", 32'(dm_we), 32'd1);
        check("R1", "store rf_we", 32'(rf_we), 32'd0);

        apply(enc_i(12'd7, 5'd0, 3'b000, 5'd11, 7'h13)); // load-immediate 7 into a1
        check("R3", "addi alu_op", 32'(alu_op), 32'd0);
        check("R8", "addi rs2 alias", 32'(rs2_idx), 32'd7);

        apply(enc_i(12'd188, 5'd0, 3'b010, 5'd13, 7'h03));
        check("R4", "load wb_sel", 32'(wb_sel), 32'd1);
        check("R4", "load dm_re", 32'(dm_re), 32'd1);

        apply(enc_r(7'h00, 5'd11, 5'd10, 3'b000, 5'd14));
        check("R6", "add alu_op", 32'(alu_op), 32'd0);
        check("R8", "add rd", 32'(rd_idx), 32'd14);
        apply(enc_r(7'h20, 5'd12, 5'd11, 3'b000, 5'd15));
        check("R6", "sub alu_op", 32'(alu_op), 32'd1);
        apply(enc_r(7'h20, 5'd2, 5'd1, 3'b101, 5'd3));
        check("R6", "sra alu_op", 32'(alu_op), 32'd7);

        apply(enc_i(12'd1, 5'd13, 3'b001, 5'd13, 7'h13));
        check("R7", "slli alu_op", 32'(alu_op), 32'd2);
        apply(enc_i(12'h403, 5'd1, 3'b101, 5'd1, 7'h13));
        check("R7", "srai alu_op", 32'(alu_op), 32'd7);
        check("R7", "srai imm", imm, 32'h0000_0403);
        apply(enc_i(12'h401, 5'd1, 3'b000, 5'd1, 7'h13));
        check("R3", "addi bit30 still add", 32'(alu_op), 32'd0);

        apply(enc_b(13'h1FF0, 5'd0, 5'd15, 3'b001));   // bne a5,x0,-16
        check("R9", "bne imm -16", imm, 32'hFFFF_FFF0);
        check("R5", "bne do_branch", 32'(do_branch), 32'd1);
        check("R5", "bne op1_pc", 32'(op1_pc), 32'd1);

        apply({20'h12345, 5'd5, 7'h37});
        check("R10", "lui imm", imm, 32'h1234_5000);
        check("R10", "lui alu_op", 32'(alu_op), 32'd10);

        apply(enc_j(21'h1FF800, 5'd1));                 // jal ra,-2048
        check("R11", "jal imm", imm, 32'hFFFF_F800);
        check("R11", "jal wb_sel", 32'(wb_sel), 32'd2);
        check("R11", "jal do_jump", 32'(do_jump), 32'd1);

        apply(32'hFFFF_FFFF);
        check("R12", "unknown rf_we", 32'(rf_we), 32'd0);
        check("R12", "unknown imm", imm, 32'd0);

        for (int n = 0; n < N_RAND; n++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            if (lfsr[31]) apply({lfsr[30:7], ops[int'(lfsr[2:0]) % 7]});
            else          apply(lfsr);
        end
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

endmodule